// File: doc/BRIEF.md
# Dynamic Reference Code Stepper

This block keeps a digital reference code for a voltage regulator in step with a 5-bit voltage identification input. It does not jump to a newly requested code. It looks at the input only on the cycle-start strobe of the first switching phase. A code counts as a request only after two consecutive strobes have seen it. The reference then moves one least-significant step (25 mV in the target encoding) toward the request once every two switching cycles. Larger codes mean higher voltages, one step per code.

The regulator's control loop uses `ref_code` as the reference that the error amplifier follows. `busy` tells the power manager that a transition is still under way. The all-ones code means shutdown. It never becomes a target, and the ramp freezes while the last sampled code is all-ones. A low `enable` blocks confirmation and stepping, but the sampler keeps watching the input.

Top module: `vid_ref_stepper`

## Requirements
- R1: In reset, and on the first clock after it, `ref_code` equals the reset code (0) and `busy` is 0.
- R2: `vid_in` is looked at only on clock edges where `cyc_start` is 1. Values it holds between strobes have no effect on `ref_code` or `busy`.
- R3: A code becomes the target only when two consecutive strobes sample the same value and that value differs from the current target. A code seen on only one strobe is dropped. `busy` rises on the clock edge of the confirming strobe.
- R4: After confirmation the first step happens on the second strobe edge that follows it. Further steps follow every second strobe. Each step moves the code by exactly one LSB.
- R5: The step direction is up when the target is above `ref_code` and down when it is below. Codes 0 through 30 are all valid targets.
- R6: `busy` stays 1 while `ref_code` differs from the target. It falls on the same edge on which `ref_code` reaches the target.
- R7: A new code confirmed during a ramp takes over as the target. The ramp continues from the present `ref_code`, and its next step comes on the second strobe after the new confirmation.
- R8: The all-ones code (31) never becomes the target. While the most recently sampled code is all-ones, `ref_code` and the step pacing hold.
- R9: While `enable` is 0, no code is confirmed and `ref_code` does not change. The sampler still records the codes it sees.
- R10: `ref_code` changes only on a strobe edge and by at most one LSB per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at the start of each phase-1 switching cycle |
| vid_in | input | 5 | Requested voltage identification code |
| enable | input | 1 | Allows confirmation and stepping when 1 |
| ref_code | output | 5 | Present reference code |
| busy | output | 1 | 1 while the reference differs from the confirmed target |

## Verification
Every result lands on a strobe edge:
- `busy` rises on the edge of the second strobe that sees a new code.
- The first step comes two strobe edges after that.
- Later steps follow every second strobe edge.
- `busy` falls on the edge whose step reaches the target.

The bench drives each strobe from a falling edge. It queues the expected reference and busy values for that strobe, and the monitor compares them on the falling edge right after the strobe's rising edge, so every comparison sees exactly one strobe's effect. The idle clocks between strobes carry glitch codes on `vid_in`, so any reaction outside a strobe would change the next comparison.

// File: rtl/vid_ref_pkg.sv
// Shared definitions for the dynamic reference stepper.
// Assumes codes are monotonic, one LSB per reference step.
package vid_ref_pkg;

    // Width of the voltage identification code
    localparam int VID_W_DEF = 5;

    // Strobes between consecutive reference steps
    localparam int STEP_PERIOD_DEF = 2;

    // Direction the reference has to move toward the target
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/vid_confirm.sv
// Samples the requested code on each cycle-start strobe and keeps the
// confirmed target. A code is adopted only when two consecutive strobes
// see it. The all-ones shutdown code is never adopted. Assumes cyc_start
// lasts one clock.
module vid_confirm #(
    parameter int                 VID_W      = vid_ref_pkg::VID_W_DEF,
    parameter logic [VID_W-1:0]   RESET_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             enable,
    input  logic [VID_W-1:0] vid_in,
    output logic [VID_W-1:0] target_q,
    output logic             confirm,
    output logic             hold
);

    localparam logic [VID_W-1:0] SHUTDOWN_CODE = '1;

    logic [VID_W-1:0] prev_q;
    logic             same_as_prev;
    logic             is_new;
    logic             not_shutdown;

    // Compare the present code with the previous sample and the target
    always_comb begin
        same_as_prev = (vid_in == prev_q);
        is_new       = (vid_in != target_q);
        not_shutdown = (vid_in != SHUTDOWN_CODE);
        confirm      = cyc_start && enable && same_as_prev && is_new && not_shutdown;
        hold         = !enable || (prev_q == SHUTDOWN_CODE);
    end

    // Keep the code seen on the most recent strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RESET_CODE;
        end else if (cyc_start) begin
            prev_q <= vid_in;
        end
    end

    // Load the target when a code is confirmed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= RESET_CODE;
        end else if (confirm) begin
            target_q <= vid_in;
        end
    end

endmodule

// File: rtl/step_pacer.sv
// Counts strobes while a ramp is active and fires one step every
// STEP_PERIOD strobes. A confirmation restarts the count, so the first
// step comes STEP_PERIOD strobes after it. Assumes restart only occurs
// on a strobe.
module step_pacer #(
    parameter int STEP_PERIOD = vid_ref_pkg::STEP_PERIOD_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic restart,
    input  logic active,
    output logic step
);

    localparam int CNT_W = (STEP_PERIOD > 1) ? $clog2(STEP_PERIOD) : 1;

    generate
        if (STEP_PERIOD <= 1) begin : g_every_strobe
            // One step on every active strobe that is not a restart
            always_comb begin
                step = cyc_start && active && !restart;
            end
        end else begin : g_counted
            localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_PERIOD - 1);
            logic [CNT_W-1:0] cnt_q;

            // Step when the count reaches its last value on an active strobe
            always_comb begin
                step = cyc_start && active && !restart && (cnt_q == LAST);
            end

            // Advance the strobe count while active, clear it on restart
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (restart) begin
                    cnt_q <= '0;
                end else if (cyc_start && active) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ref_ramp.sv
// Holds the reference code and moves it one LSB toward the target on
// each step pulse. Assumes step only fires while reference and target
// differ.
module ref_ramp #(
    parameter int                 VID_W      = vid_ref_pkg::VID_W_DEF,
    parameter logic [VID_W-1:0]   RESET_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [VID_W-1:0] target,
    output logic [VID_W-1:0] ref_q
);

    import vid_ref_pkg::*;

    step_dir_e dir;

    // Pick the direction from the target and the present reference
    always_comb begin
        if (target > ref_q) begin
            dir = DIR_UP;
        end else if (target < ref_q) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
    end

    // Apply one LSB step per step pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= RESET_CODE;
        end else if (step) begin
            case (dir)
                DIR_UP:   ref_q <= ref_q + 1'b1;
                DIR_DOWN: ref_q <= ref_q - 1'b1;
                default:  ref_q <= ref_q;
            endcase
        end
    end

endmodule

// File: rtl/vid_ref_stepper.sv
// Top of the dynamic reference stepper. It confirms requested codes
// over two strobes and ramps the reference one LSB per STEP_PERIOD
// strobes toward the confirmed target. Assumes cyc_start marks phase-1
// cycle starts and lasts one clock.
module vid_ref_stepper #(
    parameter int                 VID_W       = vid_ref_pkg::VID_W_DEF,
    parameter int                 STEP_PERIOD = vid_ref_pkg::STEP_PERIOD_DEF,
    parameter logic [VID_W-1:0]   RESET_CODE  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic [VID_W-1:0] vid_in,
    input  logic             enable,
    output logic [VID_W-1:0] ref_code,
    output logic             busy
);

    logic [VID_W-1:0] target_q;
    logic             confirm;
    logic             hold;
    logic             active;
    logic             step;

    vid_confirm #(
        .VID_W      (VID_W),
        .RESET_CODE (RESET_CODE)
    ) u_confirm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .enable    (enable),
        .vid_in    (vid_in),
        .target_q  (target_q),
        .confirm   (confirm),
        .hold      (hold)
    );

    // Ramp runs while the reference lags the target and nothing freezes it
    always_comb begin
        busy   = (ref_code != target_q);
        active = busy && !hold;
    end

    step_pacer #(
        .STEP_PERIOD (STEP_PERIOD)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .restart   (confirm),
        .active    (active),
        .step      (step)
    );

    ref_ramp #(
        .VID_W      (VID_W),
        .RESET_CODE (RESET_CODE)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .target (target_q),
        .ref_q  (ref_code)
    );

endmodule

// File: rtl/vid_ref_stepper_chk.sv
// Timing checks for the reference stepper. Attached to every instance of
// the top by the bind below. Assumes a synchronous active-low reset.
module vid_ref_stepper_chk #(
    parameter int VID_W = vid_ref_pkg::VID_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_start,
    input logic             enable,
    input logic [VID_W-1:0] ref_code,
    input logic             busy,
    input logic [VID_W-1:0] target
);

    // R10: the reference changes only on a strobe edge
    a_r10_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code != $past(ref_code)) |-> $past(cyc_start));

    // R10: a change is exactly one LSB
    a_r10_one_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code != $past(ref_code)) |->
        ((ref_code == VID_W'($past(ref_code) + 1'b1)) ||
         (ref_code == VID_W'($past(ref_code) - 1'b1))));

    // R8: shutdown code never becomes the target
    a_r8_no_shutdown_target: assert property (@(posedge clk) disable iff (!rst_n)
        target != {VID_W{1'b1}});

    // R9: with enable low the reference holds
    a_r9_enable_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> $stable(ref_code));

    // R3: busy rises only on an enabled strobe
    a_r3_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cyc_start) && $past(enable)));

    // R6: busy falls only on a strobe edge
    a_r6_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cyc_start));

endmodule

bind vid_ref_stepper vid_ref_stepper_chk #(.VID_W(VID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .enable    (enable),
    .ref_code  (ref_code),
    .busy      (busy),
    .target    (target_q)
);

// File: tb/vid_ref_stepper_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected result of each strobe,
// and the monitor compares it on the falling edge after that strobe.
module vid_ref_stepper_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       enable = 1'b0;
    logic [4:0] vid_in = 5'd0;
    logic [4:0] ref_code;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit pend = 1'b0;

    typedef struct {
        logic [4:0] ref_v;
        logic       busy_v;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // Requirement model state
    logic [4:0] m_prev = 5'd0;
    logic [4:0] m_tgt  = 5'd0;
    logic [4:0] m_ref  = 5'd0;
    int         m_cnt  = 0;

    vid_ref_stepper u_vid_ref_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .vid_in    (vid_in),
        .enable    (enable),
        .ref_code  (ref_code),
        .busy      (busy)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    // Model of one strobe, built from R3-R9
    task automatic model_strobe(input logic [4:0] v, input bit en);
        bit hold_now;
        bit conf;
        hold_now = !en || (m_prev == 5'd31);
        conf     = en && (v == m_prev) && (v != m_tgt) && (v != 5'd31);
        if (conf) begin
            m_tgt = v;
            m_cnt = 0;
        end else if ((m_ref != m_tgt) && !hold_now) begin
            if (m_cnt == 1) begin
                m_ref = (m_tgt > m_ref) ? m_ref + 5'd1 : m_ref - 5'd1;
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        m_prev = v;
    endtask

    // Driver: one strobe, expected result queued, then idle clocks
    task automatic cyc(input logic [4:0] v, input bit en, input string tag,
                       input bit use_glitch = 1'b0, input logic [4:0] glitch = 5'd0);
        exp_t e;
        @(negedge clk);
        vid_in    = v;
        enable    = en;
        cyc_start = 1'b1;
        model_strobe(v, en);
        e.ref_v  = m_ref;
        e.busy_v = (m_ref != m_tgt);
        e.tag    = tag;
        sb_q.push_back(e);
        @(negedge clk);
        cyc_start = 1'b0;
        if (use_glitch) vid_in = glitch;
        @(negedge clk);
        @(negedge clk);
        vid_in = v;
    endtask

    // Monitor: mark the strobe edge
    always @(posedge clk) begin
        if (rst_n && cyc_start) pend = 1'b1;
    end

    // Monitor: compare the queued result after the strobe edge
    always @(negedge clk) begin
        if (pend) begin
            exp_t e;
            pend = 1'b0;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: no expected item, ref=%0d busy=%0b", ref_code, busy);
            end else begin
                e = sb_q.pop_front();
                if (ref_code !== e.ref_v || busy !== e.busy_v) begin
                    errors++;
                    $display("FAIL %s: ref=%0d busy=%0b expected ref=%0d busy=%0b",
                             e.tag, ref_code, busy, e.ref_v, e.busy_v);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        checks++;
        if (ref_code !== 5'd0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1: ref=%0d busy=%0b expected ref=0 busy=0", ref_code, busy);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state on the first clock after reset
        checks++;
        if (ref_code !== 5'd0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1: ref=%0d busy=%0b expected ref=0 busy=0", ref_code, busy);
        end

        // R3 and R4: confirmation, then a ramp up to 4
        cyc(5'd4, 1'b1, "R3");
        cyc(5'd4, 1'b1, "R3");
        for (int i = 0; i < 8; i++) cyc(5'd4, 1'b1, "R4");
        for (int i = 0; i < 2; i++) cyc(5'd4, 1'b1, "R6");

        // R5: ramp down to 1
        for (int i = 0; i < 9; i++) cyc(5'd1, 1'b1, "R5");

        // R3: a code seen on one strobe only is dropped
        cyc(5'd9, 1'b1, "R3");
        cyc(5'd1, 1'b1, "R3");
        cyc(5'd1, 1'b1, "R3");

        // R2: codes between strobes are ignored
        for (int i = 0; i < 4; i++) cyc(5'd1, 1'b1, "R2", 1'b1, 5'd12);

        // R7: retarget mid-ramp
        for (int i = 0; i < 8; i++) cyc(5'd20, 1'b1, "R7");
        for (int i = 0; i < 12; i++) cyc(5'd2, 1'b1, "R7", 1'b1, 5'd17);

        // R8: shutdown code freezes the ramp and is never a target
        for (int i = 0; i < 6; i++) cyc(5'd25, 1'b1, "R8");
        for (int i = 0; i < 5; i++) cyc(5'd31, 1'b1, "R8");
        for (int i = 0; i < 50; i++) cyc(5'd25, 1'b1, "R8");

        // R9: enable low blocks confirmation and steps
        for (int i = 0; i < 4; i++) cyc(5'd10, 1'b0, "R9");
        for (int i = 0; i < 4; i++) cyc(5'd10, 1'b1, "R9");
        for (int i = 0; i < 4; i++) cyc(5'd10, 1'b0, "R9");
        for (int i = 0; i < 30; i++) cyc(5'd10, 1'b1, "R9");

        // R5 and R10: climb to the top valid code, 30
        for (int i = 0; i < 45; i++) cyc(5'd30, 1'b1, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule